// File: doc/BRIEF.md
# Private Interrupt Configuration Bank

This block holds the configuration of the 32 private interrupts of one processor core: 16 software-generated interrupts (numbers 0..15) and 16 peripheral interrupts (numbers 16..31). Software reaches it over a simple register bus. Each request carries a byte offset, an access size of 1, 4 or 8 bytes, write data and a flag that marks the master as secure. The block stores the group, group-modifier, enable, pending, active, priority, edge-trigger and non-secure access-control state. It also holds a wake register and two 64-bit base-address registers. The group, group-modifier, enable, pending, active, priority, edge-trigger and access-control state is driven straight out to the pending and selection logic next to the block.

One set of registers can look different to different masters. Each access is filtered by its secure flag and by a chip-wide security-disable input. A non-secure master sees only the interrupts that are in group 1. It sees their priorities through a view that is shifted by one bit, and it cannot reach the registers that belong only to the secure side. No access ever returns a bus error. An offset that maps to no register, an unsupported size or a misaligned address reads as zero and changes nothing, and it raises a one-cycle `guest_err` pulse.

Read data is registered: it appears on `rsp_rdata`, together with `rsp_valid`, in the cycle after the request. A write that alters interrupt state raises `update_strobe` in the cycle in which the new state first appears on the `cfg_*` outputs.

Top module: `pirq_cfg_bank`

## Requirements
- R1: An access is "restricted" when `req_secure` is 0 and `sec_disable` is 0. A restricted access reaches an enable, pending, active or edge bit only where the matching group bit is 1. The other bits read as 0 and ignore writes. An access that is not restricted reaches every bit.
- R2: Enable, pending and active each have two addresses: a set address (0x100, 0x200, 0x300) and a clear address (0x180, 0x280, 0x380). A write to the set address ORs the permitted data bits into the state. A write to the clear address clears the permitted bits that are 1 in the data. Both addresses read the same state.
- R3: Priority views for a restricted access:
  - For an interrupt in group 1, the priority byte reads as the stored value shifted left by one, truncated to 8 bits.
  - A write to such a byte stores 0x80 OR (data >> 1).
  - For an interrupt in group 0, the priority byte reads as 0 and ignores writes.
- R4: The priority bytes sit at offsets 0x400..0x41F, one byte per interrupt. They accept byte accesses and aligned word accesses. In a word, the lowest-numbered interrupt is in bits 7:0.
- R5: Access gating for the group-type registers:
  - The group register (0x080) reads 0 and ignores writes for a restricted access.
  - The group-modifier register (0xD00) and the access-control register (0xE00) read 0 and ignore writes unless `req_secure` is 1 and `sec_disable` is 0.
- R6: Edge-trigger words:
  - A write to the upper edge word (0xC04) sets the edge bit of peripheral interrupt 16+k from data bit 2k+1, for k = 0..15.
  - A read of the upper edge word returns each edge bit in bit 2k+1, with every even bit 0.
  - The lower edge word (0xC00) reads 0 and ignores writes.
- R7: In the wake register (0x014), only bit 0 (sleep request) can be written. Bit 1 (children asleep) always reads equal to bit 0. All other bits read 0.
- R8: 64-bit registers:
  - The base registers (0x018, 0x020) accept an 8-byte access or a 4-byte access to either half. The upper half sits at offset +4.
  - The type register (0x008) reads the `TYPE_VALUE` parameter and ignores writes. A write to it, or to the identification register (0x004), raises `guest_err`.
- R9: Inert registers and bad accesses:
  - The control register (0x000) and the status register (0x010) read 0 and ignore writes.
  - An unmapped offset, or a size other than 1, 4 or 8, reads as 0 and ignores writes. It raises a one-cycle `guest_err`.
  - Byte access is valid only for the priority bytes. 8-byte access is valid only for the 64-bit registers.
- R10: An access whose offset is not a multiple of its size is handled like an unmapped offset.
- R11: `update_strobe` is 1 for exactly one cycle after a write that changes group, enable, pending, active, priority or edge state. It stays 0 for a write that leaves this state unchanged.
- R12: After reset, all state and outputs are 0. A read returns its data with `rsp_valid` = 1 in the next cycle. `rsp_valid` is 0 after a write or an idle cycle. The identification register (0x004) reads the `ID_VALUE` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | Chip-wide security disable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Request comes from a secure master |
| req_size | input | 4 | Access size in bytes (1, 4 or 8) |
| req_offset | input | OFF_W | Byte offset within the bank |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 64 | Read data |
| guest_err | output | 1 | One-cycle pulse for a bad access or a write to a read-only register |
| update_strobe | output | 1 | One-cycle pulse after the interrupt state changes |
| cfg_group | output | 32 | Group bits |
| cfg_grpmod | output | 32 | Group-modifier bits |
| cfg_enable | output | 32 | Enable bits |
| cfg_pending | output | 32 | Pending bits |
| cfg_active | output | 32 | Active bits |
| cfg_edge | output | 16 | Edge-trigger bits of peripheral interrupts 16..31 |
| cfg_nsacc | output | 32 | Non-secure access control |
| cfg_prio | output | 256 | Priority bytes; interrupt n is in bits 8n+7:8n |

## Verification
The properties assume that the request fields are stable and defined whenever `req_valid` is 1. They also assume that `sec_disable` does not change in the same cycle as a request whose restriction it decides. The stimulus drives every field on the falling edge and holds it for one full cycle. It changes `sec_disable` only together with a new request and lowers `req_valid` between requests. With that, each property can relate one request to the state seen in the next cycle without overlap from the one before.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int NIRQ   = 32;
    localparam int NSGI   = 16;
    localparam int NPPI   = NIRQ - NSGI;
    localparam int BUS_W  = 64;
    localparam int PIDX_W = $clog2(NIRQ);

    localparam int OFF_CTRL   = 'h000;
    localparam int OFF_IDENT  = 'h004;
    localparam int OFF_TYPE   = 'h008;
    localparam int OFF_STATUS = 'h010;
    localparam int OFF_WAKE   = 'h014;
    localparam int OFF_BASE_A = 'h018;
    localparam int OFF_BASE_B = 'h020;
    localparam int OFF_GROUP  = 'h080;
    localparam int OFF_EN_S   = 'h100;
    localparam int OFF_EN_C   = 'h180;
    localparam int OFF_PD_S   = 'h200;
    localparam int OFF_PD_C   = 'h280;
    localparam int OFF_AC_S   = 'h300;
    localparam int OFF_AC_C   = 'h380;
    localparam int OFF_PRIO   = 'h400;
    localparam int OFF_TRIG0  = 'hC00;
    localparam int OFF_TRIG1  = 'hC04;
    localparam int OFF_GRPMOD = 'hD00;
    localparam int OFF_NSACC  = 'hE00;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_CTRL, SEL_IDENT, SEL_TYPE, SEL_STATUS, SEL_WAKE,
        SEL_BASE_A, SEL_BASE_B, SEL_GROUP, SEL_EN_S, SEL_EN_C, SEL_PD_S,
        SEL_PD_C, SEL_AC_S, SEL_AC_C, SEL_PRIO, SEL_TRIG0, SEL_TRIG1,
        SEL_GRPMOD, SEL_NSACC
    } reg_sel_e;

    typedef struct packed {
        logic [NIRQ-1:0]   group;
        logic [NIRQ-1:0]   grpmod;
        logic [NIRQ-1:0]   enable;
        logic [NIRQ-1:0]   pending;
        logic [NIRQ-1:0]   active;
        logic [NIRQ-1:0]   nsacc;
        logic [NPPI-1:0]   edge_cfg;
        logic [NIRQ*8-1:0] prio;
        logic              sleep;
        logic [BUS_W-1:0]  base_a;
        logic [BUS_W-1:0]  base_b;
        logic [BUS_W-1:0]  rdata;
        logic              rvalid;
        logic              err;
        logic              strobe;
    } bank_st_t;

    // place edge bit k into odd position 2k+1
    function automatic logic [31:0] spread_odd(input logic [NPPI-1:0] e);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < NPPI; k++) w[2*k+1] = e[k];
        return w;
    endfunction

    // take odd position 2k+1 into edge bit k
    function automatic logic [NPPI-1:0] gather_odd(input logic [31:0] w);
        logic [NPPI-1:0] e;
        for (int k = 0; k < NPPI; k++) e[k] = w[2*k+1];
        return e;
    endfunction
endpackage

// File: rtl/pirq_addr_decode.sv
module pirq_addr_decode
    import pirq_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [3:0]        size,
    output reg_sel_e          sel,
    output logic              hi_half,
    output logic [PIDX_W-1:0] pidx
);
    localparam logic [OFF_W-1:0] PRIO_LO = OFF_W'(OFF_PRIO);
    localparam logic [OFF_W-1:0] PRIO_HI = OFF_W'(OFF_PRIO + NIRQ);

    logic             in_prio;
    logic [OFF_W-1:0] rel;

    assign rel     = offset - PRIO_LO;
    assign pidx    = rel[PIDX_W-1:0];
    assign in_prio = (offset >= PRIO_LO) && (offset < PRIO_HI);

    always_comb begin
        sel     = SEL_NONE;
        hi_half = 1'b0;
        case (size)
            4'd1: begin
                if (in_prio) sel = SEL_PRIO;
            end
            4'd4: begin
                if (offset[1:0] == 2'b00) begin
                    if (in_prio) begin
                        sel = SEL_PRIO;
                    end else begin
                        case (offset)
                            OFF_W'(OFF_CTRL):     sel = SEL_CTRL;
                            OFF_W'(OFF_IDENT):    sel = SEL_IDENT;
                            OFF_W'(OFF_TYPE):     sel = SEL_TYPE;
                            OFF_W'(OFF_TYPE + 4): begin sel = SEL_TYPE; hi_half = 1'b1; end
                            OFF_W'(OFF_STATUS):   sel = SEL_STATUS;
                            OFF_W'(OFF_WAKE):     sel = SEL_WAKE;
                            OFF_W'(OFF_BASE_A):   sel = SEL_BASE_A;
                            OFF_W'(OFF_BASE_A + 4): begin sel = SEL_BASE_A; hi_half = 1'b1; end
                            OFF_W'(OFF_BASE_B):   sel = SEL_BASE_B;
                            OFF_W'(OFF_BASE_B + 4): begin sel = SEL_BASE_B; hi_half = 1'b1; end
                            OFF_W'(OFF_GROUP):    sel = SEL_GROUP;
                            OFF_W'(OFF_EN_S):     sel = SEL_EN_S;
                            OFF_W'(OFF_EN_C):     sel = SEL_EN_C;
                            OFF_W'(OFF_PD_S):     sel = SEL_PD_S;
                            OFF_W'(OFF_PD_C):     sel = SEL_PD_C;
                            OFF_W'(OFF_AC_S):     sel = SEL_AC_S;
                            OFF_W'(OFF_AC_C):     sel = SEL_AC_C;
                            OFF_W'(OFF_TRIG0):    sel = SEL_TRIG0;
                            OFF_W'(OFF_TRIG1):    sel = SEL_TRIG1;
                            OFF_W'(OFF_GRPMOD):   sel = SEL_GRPMOD;
                            OFF_W'(OFF_NSACC):    sel = SEL_NSACC;
                            default:              sel = SEL_NONE;
                        endcase
                    end
                end
            end
            4'd8: begin
                if (offset[2:0] == 3'b000) begin
                    case (offset)
                        OFF_W'(OFF_TYPE):   sel = SEL_TYPE;
                        OFF_W'(OFF_BASE_A): sel = SEL_BASE_A;
                        OFF_W'(OFF_BASE_B): sel = SEL_BASE_B;
                        default:            sel = SEL_NONE;
                    endcase
                end
            end
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/pirq_sec_gate.sv
module pirq_sec_gate
    import pirq_pkg::*;
(
    input  logic            secure,
    input  logic            sec_disable,
    input  logic [NIRQ-1:0] group,
    output logic            ns_restrict,
    output logic [NIRQ-1:0] bit_mask,
    output logic            group_ok,
    output logic            secure_only_ok
);
    assign ns_restrict    = !secure && !sec_disable;
    assign bit_mask       = ns_restrict ? group : '1;
    assign group_ok       = !ns_restrict;
    assign secure_only_ok = secure && !sec_disable;
endmodule

// File: rtl/pirq_prio_lane.sv
module pirq_prio_lane (
    input  logic [7:0] stored,
    input  logic [7:0] wbyte,
    input  logic       we,
    input  logic       grp_bit,
    input  logic       ns_restrict,
    output logic [7:0] rd_view,
    output logic [7:0] nxt
);
    logic permit;

    assign permit = !ns_restrict || grp_bit;

    always_comb begin
        if (!permit)          rd_view = 8'h00;
        else if (ns_restrict) rd_view = {stored[6:0], 1'b0};
        else                  rd_view = stored;

        if (we && permit) nxt = ns_restrict ? {1'b1, wbyte[7:1]} : wbyte;
        else              nxt = stored;
    end
endmodule

// File: rtl/pirq_cfg_bank.sv
module pirq_cfg_bank
    import pirq_pkg::*;
#(
    parameter int          OFF_W      = 16,
    parameter logic [31:0] ID_VALUE   = 32'h5A17_0001,
    parameter logic [63:0] TYPE_VALUE = 64'h0000_0001_0000_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_disable,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [3:0]        req_size,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              guest_err,
    output logic              update_strobe,
    output logic [31:0]       cfg_group,
    output logic [31:0]       cfg_grpmod,
    output logic [31:0]       cfg_enable,
    output logic [31:0]       cfg_pending,
    output logic [31:0]       cfg_active,
    output logic [15:0]       cfg_edge,
    output logic [31:0]       cfg_nsacc,
    output logic [255:0]      cfg_prio
);
    bank_st_t st_d, st_q;

    reg_sel_e          sel;
    logic              hi_half;
    logic [PIDX_W-1:0] pidx;
    logic              ns_restrict;
    logic [NIRQ-1:0]   bit_mask;
    logic              group_ok;
    logic              secure_only_ok;
    logic              wr_go;
    logic [NIRQ*8-1:0] view_flat;
    logic [NIRQ*8-1:0] nxt_flat;
    logic [NIRQ-1:0]   lane_we;

    pirq_addr_decode #(.OFF_W(OFF_W)) dec_i (
        .offset  (req_offset),
        .size    (req_size),
        .sel     (sel),
        .hi_half (hi_half),
        .pidx    (pidx)
    );

    pirq_sec_gate gate_i (
        .secure         (req_secure),
        .sec_disable    (sec_disable),
        .group          (st_q.group),
        .ns_restrict    (ns_restrict),
        .bit_mask       (bit_mask),
        .group_ok       (group_ok),
        .secure_only_ok (secure_only_ok)
    );

    assign wr_go = req_valid && req_write;

    for (genvar i = 0; i < NIRQ; i++) begin : g_lane
        logic [7:0] wbyte;
        assign lane_we[i] = wr_go && (sel == SEL_PRIO) &&
                            ((req_size == 4'd1) ? (pidx == PIDX_W'(i))
                                                : (pidx[PIDX_W-1:2] == (PIDX_W-2)'(i / 4)));
        assign wbyte = (req_size == 4'd1) ? req_wdata[7:0] : req_wdata[(i % 4)*8 +: 8];
        pirq_prio_lane lane_i (
            .stored      (st_q.prio[i*8 +: 8]),
            .wbyte       (wbyte),
            .we          (lane_we[i]),
            .grp_bit     (st_q.group[i]),
            .ns_restrict (ns_restrict),
            .rd_view     (view_flat[i*8 +: 8]),
            .nxt         (nxt_flat[i*8 +: 8])
        );
    end

    always_comb begin
        logic [31:0] w32;
        logic [31:0] rd32;
        logic [63:0] rd64;
        logic        use64;

        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.rvalid = req_valid && !req_write;
        st_d.err    = req_valid && ((sel == SEL_NONE) ||
                      (req_write && ((sel == SEL_IDENT) || (sel == SEL_TYPE))));
        st_d.strobe = 1'b0;
        w32         = req_wdata[31:0];
        rd32        = '0;
        rd64        = '0;
        use64       = 1'b0;

        // read path
        case (sel)
            SEL_IDENT:  rd32 = ID_VALUE;
            SEL_TYPE: begin
                use64 = (req_size == 4'd8);
                rd64  = TYPE_VALUE;
                rd32  = hi_half ? TYPE_VALUE[63:32] : TYPE_VALUE[31:0];
            end
            SEL_WAKE:   rd32 = {30'd0, st_q.sleep, st_q.sleep};
            SEL_BASE_A: begin
                use64 = (req_size == 4'd8);
                rd64  = st_q.base_a;
                rd32  = hi_half ? st_q.base_a[63:32] : st_q.base_a[31:0];
            end
            SEL_BASE_B: begin
                use64 = (req_size == 4'd8);
                rd64  = st_q.base_b;
                rd32  = hi_half ? st_q.base_b[63:32] : st_q.base_b[31:0];
            end
            SEL_GROUP:  rd32 = group_ok ? st_q.group : '0;
            SEL_EN_S, SEL_EN_C: rd32 = st_q.enable & bit_mask;
            SEL_PD_S, SEL_PD_C: rd32 = st_q.pending & bit_mask;
            SEL_AC_S, SEL_AC_C: rd32 = st_q.active & bit_mask;
            SEL_PRIO: begin
                if (req_size == 4'd1) rd32 = {24'd0, view_flat[{pidx, 3'b000} +: 8]};
                else                  rd32 = view_flat[{pidx[PIDX_W-1:2], 5'b00000} +: 32];
            end
            SEL_TRIG1:  rd32 = spread_odd(st_q.edge_cfg & bit_mask[NIRQ-1:NSGI]);
            SEL_GRPMOD: rd32 = secure_only_ok ? st_q.grpmod : '0;
            SEL_NSACC:  rd32 = secure_only_ok ? st_q.nsacc : '0;
            default:    rd32 = '0;
        endcase
        if (req_valid && !req_write) st_d.rdata = use64 ? rd64 : {32'd0, rd32};

        // write path
        if (wr_go) begin
            case (sel)
                SEL_WAKE:   st_d.sleep = w32[0];
                SEL_BASE_A: begin
                    if (req_size == 4'd8) st_d.base_a = req_wdata;
                    else if (hi_half)     st_d.base_a[63:32] = w32;
                    else                  st_d.base_a[31:0]  = w32;
                end
                SEL_BASE_B: begin
                    if (req_size == 4'd8) st_d.base_b = req_wdata;
                    else if (hi_half)     st_d.base_b[63:32] = w32;
                    else                  st_d.base_b[31:0]  = w32;
                end
                SEL_GROUP:  if (group_ok) st_d.group = w32;
                SEL_EN_S:   st_d.enable  = st_q.enable  |  (w32 & bit_mask);
                SEL_EN_C:   st_d.enable  = st_q.enable  & ~(w32 & bit_mask);
                SEL_PD_S:   st_d.pending = st_q.pending |  (w32 & bit_mask);
                SEL_PD_C:   st_d.pending = st_q.pending & ~(w32 & bit_mask);
                SEL_AC_S:   st_d.active  = st_q.active  |  (w32 & bit_mask);
                SEL_AC_C:   st_d.active  = st_q.active  & ~(w32 & bit_mask);
                SEL_PRIO:   st_d.prio    = nxt_flat;
                SEL_TRIG1:  st_d.edge_cfg = (st_q.edge_cfg & ~bit_mask[NIRQ-1:NSGI]) |
                                            (gather_odd(w32) & bit_mask[NIRQ-1:NSGI]);
                SEL_GRPMOD: if (secure_only_ok) st_d.grpmod = w32;
                SEL_NSACC:  if (secure_only_ok) st_d.nsacc  = w32;
                default: ;
            endcase
        end

        st_d.strobe = (st_d.group   != st_q.group)   || (st_d.enable != st_q.enable) ||
                      (st_d.pending != st_q.pending) || (st_d.active != st_q.active) ||
                      (st_d.prio    != st_q.prio)    || (st_d.edge_cfg != st_q.edge_cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid     = st_q.rvalid;
    assign rsp_rdata     = st_q.rdata;
    assign guest_err     = st_q.err;
    assign update_strobe = st_q.strobe;
    assign cfg_group     = st_q.group;
    assign cfg_grpmod    = st_q.grpmod;
    assign cfg_enable    = st_q.enable;
    assign cfg_pending   = st_q.pending;
    assign cfg_active    = st_q.active;
    assign cfg_edge      = st_q.edge_cfg;
    assign cfg_nsacc     = st_q.nsacc;
    assign cfg_prio      = st_q.prio;
endmodule

// File: rtl/pirq_cfg_bank_chk.sv
module pirq_cfg_bank_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         sec_disable,
    input logic         req_valid,
    input logic         req_write,
    input logic         req_secure,
    input logic         rsp_valid,
    input logic         guest_err,
    input logic         update_strobe,
    input logic [31:0]  cfg_group,
    input logic [31:0]  cfg_grpmod,
    input logic [31:0]  cfg_nsacc,
    input logic [31:0]  cfg_enable,
    input logic [255:0] cfg_prio
);
    logic ns_wr;
    logic so_blocked_wr;

    assign ns_wr         = req_valid && req_write && !req_secure && !sec_disable;
    assign so_blocked_wr = req_valid && req_write && (!req_secure || sec_disable);

    AST_NS_BITMAP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ns_wr |=> (((cfg_enable ^ $past(cfg_enable)) & ~$past(cfg_group)) == 32'd0)); // R1

    AST_NS_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ns_wr |=> $stable(cfg_group)); // R5

    AST_SECURE_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        so_blocked_wr |=> ($stable(cfg_grpmod) && $stable(cfg_nsacc))); // R5

    for (genvar i = 0; i < 32; i++) begin : g_prio
        AST_NS_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            ns_wr |=> ($stable(cfg_prio[i*8 +: 8]) || cfg_prio[i*8+7])); // R3
    end

    AST_RSP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R12

    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R12

    AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        guest_err |-> !update_strobe); // R9

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !update_strobe); // R11

    AST_ENABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_enable) |-> update_strobe); // R11
endmodule

bind pirq_cfg_bank pirq_cfg_bank_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_disable   (sec_disable),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_secure    (req_secure),
    .rsp_valid     (rsp_valid),
    .guest_err     (guest_err),
    .update_strobe (update_strobe),
    .cfg_group     (cfg_group),
    .cfg_grpmod    (cfg_grpmod),
    .cfg_nsacc     (cfg_nsacc),
    .cfg_enable    (cfg_enable),
    .cfg_prio      (cfg_prio)
);

// File: tb/pirq_cfg_bank_tb_top.sv
module pirq_cfg_bank_tb_top;
    localparam logic [31:0] ID_V   = 32'h5A17_0001;
    localparam logic [63:0] TYPE_V = 64'h0000_0001_0000_0010;

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic        sdis;
        logic [3:0]  size;
        logic [15:0] off;
        logic [63:0] data;
        logic [63:0] exp;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 69;
    localparam vec_t VECS [NV] = '{
        '{1,1,0,4,16'h080,64'hFFFF00F0,0,5},              // R5 group setup
        '{0,1,0,4,16'h080,0,64'hFFFF00F0,5},
        '{0,0,0,4,16'h080,0,64'h0,5},
        '{1,0,0,4,16'h080,64'h0,0,5},
        '{0,1,0,4,16'h080,0,64'hFFFF00F0,5},
        '{1,0,0,4,16'h100,64'hFFFFFFFF,0,1},              // R1 masked set
        '{0,1,0,4,16'h180,0,64'hFFFF00F0,2},              // R2 clear addr reads state
        '{1,1,0,4,16'h100,64'h0000000F,0,2},
        '{0,0,0,4,16'h100,0,64'hFFFF00F0,1},
        '{1,0,0,4,16'h180,64'h000000FF,0,1},
        '{0,1,0,4,16'h100,0,64'hFFFF000F,1},
        '{1,1,0,4,16'h200,64'h3,0,2},                     // R2 pending
        '{1,1,0,4,16'h280,64'h1,0,2},
        '{0,1,0,4,16'h200,0,64'h2,2},
        '{1,1,0,4,16'h300,64'h80000001,0,2},
        '{0,0,0,4,16'h380,0,64'h80000000,1},
        '{0,0,1,4,16'h100,0,64'hFFFF000F,1},
        '{0,0,1,4,16'h080,0,64'hFFFF00F0,5},
        '{1,1,0,4,16'h400,64'h44332211,0,4},              // R4 byte order
        '{0,1,0,1,16'h400,0,64'h11,4},
        '{0,1,0,1,16'h403,0,64'h44,4},
        '{1,0,0,1,16'h404,64'h40,0,3},                    // R3 shifted store
        '{0,1,0,1,16'h404,0,64'hA0,3},
        '{0,0,0,1,16'h404,0,64'h40,3},
        '{1,0,0,4,16'h400,64'hFFFFFFFF,0,3},
        '{0,1,0,4,16'h400,0,64'h44332211,3},
        '{0,0,0,4,16'h400,0,64'h0,3},
        '{1,1,0,4,16'h404,64'h87654321,0,4},
        '{0,0,0,4,16'h404,0,64'h0ECA8642,3},
        '{0,1,0,4,16'h404,0,64'h87654321,4},
        '{1,1,0,4,16'hC04,64'hAAAAAAAA,0,6},              // R6 odd bits
        '{0,1,0,4,16'hC04,0,64'hAAAAAAAA,6},
        '{1,1,0,4,16'hC04,64'h80000008,0,6},
        '{0,0,0,4,16'hC04,0,64'h80000008,6},
        '{1,1,0,4,16'hC04,64'h55555555,0,6},
        '{0,1,0,4,16'hC04,0,64'h0,6},
        '{1,1,0,4,16'hC00,64'hFFFFFFFF,0,6},
        '{0,1,0,4,16'hC00,0,64'h0,6},
        '{1,1,0,4,16'h014,64'hFFFF,0,7},                  // R7 wake
        '{0,1,0,4,16'h014,0,64'h3,7},
        '{1,1,0,4,16'h014,64'h2,0,7},
        '{0,1,0,4,16'h014,0,64'h0,7},
        '{1,1,0,8,16'h018,64'h1122334455667788,0,8},      // R8 base halves
        '{0,1,0,4,16'h018,0,64'h55667788,8},
        '{0,1,0,4,16'h01C,0,64'h11223344,8},
        '{1,1,0,4,16'h01C,64'hDEADBEEF,0,8},
        '{0,1,0,8,16'h018,0,64'hDEADBEEF55667788,8},
        '{1,1,0,4,16'h020,64'hCAFEF00D,0,8},
        '{0,1,0,8,16'h020,0,64'h00000000CAFEF00D,8},
        '{0,1,0,8,16'h008,0,TYPE_V,8},
        '{1,1,0,8,16'h008,64'h0,0,8},
        '{0,1,0,8,16'h008,0,TYPE_V,8},
        '{0,1,0,4,16'h00C,0,64'h1,8},
        '{1,1,0,4,16'h000,64'hFFFFFFFF,0,9},              // R9 inert
        '{0,1,0,4,16'h000,0,64'h0,9},
        '{1,1,0,4,16'h010,64'hFFFFFFFF,0,9},
        '{0,1,0,4,16'h010,0,64'h0,9},
        '{1,1,0,4,16'hD00,64'h12345678,0,5},
        '{0,1,0,4,16'hD00,0,64'h12345678,5},
        '{0,0,0,4,16'hD00,0,64'h0,5},
        '{1,0,0,4,16'hD00,64'h0,0,5},
        '{0,1,1,4,16'hD00,0,64'h0,5},
        '{1,1,1,4,16'hD00,64'h0,0,5},
        '{0,1,0,4,16'hD00,0,64'h12345678,5},
        '{1,1,0,4,16'hE00,64'h0000FFFF,0,5},
        '{0,0,0,4,16'hE00,0,64'h0,5},
        '{0,1,0,4,16'hE00,0,64'h0000FFFF,5},
        '{1,1,0,4,16'h102,64'hFFFFFFFF,0,10},             // R10 misaligned write
        '{0,1,0,4,16'h100,0,64'hFFFF000F,10}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sec_disable = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic         req_secure = 1'b0;
    logic [3:0]   req_size = 4'd4;
    logic [15:0]  req_offset = '0;
    logic [63:0]  req_wdata = '0;
    logic         rsp_valid, guest_err, update_strobe;
    logic [63:0]  rsp_rdata;
    logic [31:0]  cfg_group, cfg_grpmod, cfg_enable, cfg_pending, cfg_active, cfg_nsacc;
    logic [15:0]  cfg_edge;
    logic [255:0] cfg_prio;

    int checks = 0;
    int errors = 0;
    logic [63:0] got_rd;
    logic        got_rv, got_err, got_stb;

    always #5 clk = ~clk;

    pirq_cfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
        .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
        .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .guest_err(guest_err),
        .update_strobe(update_strobe), .cfg_group(cfg_group), .cfg_grpmod(cfg_grpmod),
        .cfg_enable(cfg_enable), .cfg_pending(cfg_pending), .cfg_active(cfg_active),
        .cfg_edge(cfg_edge), .cfg_nsacc(cfg_nsacc), .cfg_prio(cfg_prio)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic sec, input logic sdis,
                        input logic [3:0] sz, input logic [15:0] off, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_secure = sec; sec_disable = sdis;
        req_size = sz; req_offset = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        got_rd = rsp_rdata; got_rv = rsp_valid; got_err = guest_err; got_stb = update_strobe;
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset enable", {32'd0, cfg_enable}, 64'd0);
        chk("R12 reset group", {32'd0, cfg_group}, 64'd0);
        chk("R12 reset prio", {63'd0, |cfg_prio}, 64'd0);
        chk("R12 reset outputs", {61'd0, rsp_valid, guest_err, update_strobe}, 64'd0);
        xfer(0, 1, 0, 4, 16'h004, 0);
        chk("R12 ident read", got_rd, {32'd0, ID_V});
        chk("R12 rsp_valid after read", {63'd0, got_rv}, 64'd1);

        for (int v = 0; v < NV; v++) begin
            xfer(VECS[v].wr, VECS[v].sec, VECS[v].sdis, VECS[v].size, VECS[v].off, VECS[v].data);
            if (!VECS[v].wr)
                chk($sformatf("R%0d vector %0d", VECS[v].tag, v), got_rd, VECS[v].exp);
        end

        // R11 strobe behaviour
        xfer(1, 1, 0, 4, 16'h100, 64'h1);
        chk("R11 no strobe on unchanged write", {63'd0, got_stb}, 64'd0);
        chk("R12 rsp_valid low after write", {63'd0, got_rv}, 64'd0);
        xfer(1, 1, 0, 4, 16'h100, 64'h100);
        chk("R11 strobe on enable change", {63'd0, got_stb}, 64'd1);
        chk("R11 enable visible with strobe", {32'd0, cfg_enable}, 64'hFFFF010F);
        @(negedge clk);
        chk("R11 strobe one cycle", {63'd0, update_strobe}, 64'd0);
        xfer(1, 0, 0, 4, 16'h180, 64'h0000000F);
        chk("R1 ns clear of group-0 bits ignored", {32'd0, cfg_enable}, 64'hFFFF010F);
        chk("R11 no strobe on ignored write", {63'd0, got_stb}, 64'd0);
        xfer(1, 1, 0, 1, 16'h405, 64'h99);
        chk("R11 strobe on priority change", {63'd0, got_stb}, 64'd1);
        chk("R4 prio export lane 5", {56'd0, cfg_prio[47:40]}, 64'h99);
        chk("R6 edge export cleared", {48'd0, cfg_edge}, 64'd0);

        // R8 / R9 / R10 guest error pulses
        xfer(1, 1, 0, 8, 16'h008, 64'hFFFF);
        chk("R8 type write flagged", {63'd0, got_err}, 64'd1);
        xfer(1, 1, 0, 4, 16'h004, 64'hFFFF);
        chk("R8 ident write flagged", {63'd0, got_err}, 64'd1);
        xfer(0, 1, 0, 4, 16'h004, 0);
        chk("R8 ident unchanged", got_rd, {32'd0, ID_V});
        chk("R9 no error on valid read", {63'd0, got_err}, 64'd0);
        xfer(0, 1, 0, 4, 16'hF00, 0);
        chk("R9 unmapped read zero", got_rd, 64'd0);
        chk("R9 unmapped read flagged", {63'd0, got_err}, 64'd1);
        @(negedge clk);
        chk("R9 error one cycle", {63'd0, guest_err}, 64'd0);
        xfer(0, 1, 0, 2, 16'h080, 0);
        chk("R9 size 2 flagged", {63'd0, got_err}, 64'd1);
        chk("R9 size 2 reads zero", got_rd, 64'd0);
        xfer(0, 1, 0, 1, 16'h080, 0);
        chk("R9 byte to bitmap flagged", {63'd0, got_err}, 64'd1);
        xfer(0, 1, 0, 8, 16'h100, 0);
        chk("R9 8-byte to bitmap reads zero", got_rd, 64'd0);
        xfer(0, 1, 0, 4, 16'h082, 0);
        chk("R10 misaligned word flagged", {63'd0, got_err}, 64'd1);
        xfer(0, 1, 0, 8, 16'h01C, 0);
        chk("R10 misaligned double reads zero", got_rd, 64'd0);
        xfer(1, 1, 0, 4, 16'hF00, 64'hFFFFFFFF);
        chk("R9 unmapped write no strobe", {63'd0, got_stb}, 64'd0);
        chk("R9 unmapped write leaves enable", {32'd0, cfg_enable}, 64'hFFFF010F);

        // R12 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 re-reset enable", {32'd0, cfg_enable}, 64'd0);
        chk("R12 re-reset grpmod", {32'd0, cfg_grpmod}, 64'd0);
        xfer(0, 1, 0, 8, 16'h018, 0);
        chk("R12 re-reset base", got_rd, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule